// File: doc/BRIEF.md
# Zone-Partitioned RAM Access Gate

This block sits between the requesters of a processor subsystem and a set of on-chip RAM blocks. There are three requesters: the CPU, a debug port and a co-processor. Each RAM block is owned by one of two security zones (zone 1 or zone 2), is open to everyone, or is sealed. Ownership is taken from two redundant 2-bit claim fields per block, one per zone. The two fields must agree, or the block becomes sealed.

For every access the gate decides combinationally whether it may proceed. The access is an instruction fetch, a data read or a data write. The decision uses the requester, the target block's owner, whether the owning zone is locked, and the zone that the CPU's current code is being fetched from. The gate never stalls a requester. A refused write never reaches the RAM. A refused read still returns a response one cycle later, and its data is forced to zero in the cycle the data is returned.

A per-block execute-only mask forbids data reads of a locked zone's code, while still allowing it to be fetched. A separate field places the co-processor in a zone, and that field decides what the co-processor may touch.

Top module: `zone_access_filter`

## Requirements
- R1: Block ownership is decoded from its claim fields. Block i uses bits [2i+1:2i] of `claim_z1` and of `claim_z2`; values 01 and 10 are "partial" claims. Z1 partial with Z2 = 11 gives zone 1. Z1 = 11 with Z2 partial gives zone 2. Both 11 gives an open block. Both partial gives a sealed block.
- R2: A block is sealed if either of its claim fields is 00, or if both are partial. A request whose `req_blk` is not below NB also counts as sealed. Every access to a sealed block is refused, whatever the requester or operation.
- R3: A CPU fetch (`req_master` = 00, `req_op` = 00) is granted on any open or zone-owned block. This holds for any lock state and any `fetch_zone`.
- R4: CPU data reads (`req_op` = 01) and writes (`req_op` = 10) are always granted on open blocks. On a block of a locked zone, they are granted only when `fetch_zone` equals that zone (01 = zone 1, 10 = zone 2, 00 = none).
- R5: When a block's `xonly_mask` bit is set and its zone is locked, CPU data reads are refused even when `fetch_zone` matches. CPU fetches and CPU writes still follow R3 and R4.
- R6: Debug-port requests (`req_master` = 01) are refused on any block of a locked zone and granted on open blocks. Lock bit 0 of `zone_locked` is zone 1 and bit 1 is zone 2.
- R7: When a zone is unlocked, CPU and debug-port requests to its blocks are granted, regardless of `fetch_zone` and `xonly_mask`.
- R8: Co-processor requests (`req_master` = 10) depend on `cop_zone` (00 none, 01 zone 1, 10 zone 2, 11 treated as none). With no zone, every operation is granted on open blocks and refused on owned blocks. With a zone, every operation on a block of that zone is granted, and every operation on a block of the other zone is refused. On an open block, a co-processor with a zone is refused fetches but granted reads and writes.
- R9: Every fetch or read request gives `rsp_valid` high in the next cycle. `rsp_rdata` carries `mem_rdata` if the request was granted, and zero if it was refused.
- R10: `mem_en` and `mem_we` are low for any refused request, so a refused write never reaches the RAM. A write request gives no response.
- R11: Following reset, `rsp_valid` is low and `rsp_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_master | input | 2 | Requester: 00 CPU, 01 debug port, 10 co-processor |
| req_op | input | 2 | Operation: 00 fetch, 01 read, 10 write |
| req_blk | input | BLK_W | Target RAM block index |
| req_wdata | input | DATA_W | Write data |
| fetch_zone | input | 2 | Zone of the memory the CPU currently fetches from |
| zone_locked | input | 2 | Lock state per zone (bit0 zone 1, bit1 zone 2) |
| claim_z1 | input | 2*NB | Zone-1 claim fields, two bits per block |
| claim_z2 | input | 2*NB | Zone-2 claim fields, two bits per block |
| cop_zone | input | 2 | Zone the co-processor belongs to |
| xonly_mask | input | NB | Execute-only flag per block |
| acc_grant | output | 1 | Current request is granted |
| mem_en | output | 1 | RAM enable |
| mem_we | output | 1 | RAM write enable |
| mem_blk | output | BLK_W | RAM block select |
| mem_wdata | output | DATA_W | RAM write data |
| mem_rdata | input | DATA_W | RAM read data, one cycle after `mem_en` |
| rsp_valid | output | 1 | Read response present |
| rsp_rdata | output | DATA_W | Read response data, zero if refused |

## Verification
The hardest situation to reach is the narrow corner where a locked zone's block is read by code of the same zone while the block is execute-only. In that corner the result hinges on the operation alone. The stimulus table builds it by setting the claim fields of one target block while every other block stays open. It then steps fetch, read and write on that block with the same `fetch_zone` and lock state. Claim-field pairs that disagree, and an index above the last block, are applied in the same way, with the response data checked a cycle later.

// File: rtl/zaf_pkg.sv
package zaf_pkg;

    typedef enum logic [1:0] {
        MST_CPU = 2'b00,
        MST_DBG = 2'b01,
        MST_COP = 2'b10,
        MST_RSV = 2'b11
    } master_e;

    typedef enum logic [1:0] {
        OP_FETCH = 2'b00,
        OP_READ  = 2'b01,
        OP_WRITE = 2'b10,
        OP_RSV   = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ZN_NONE = 2'b00,
        ZN_1    = 2'b01,
        ZN_2    = 2'b10,
        ZN_RSV  = 2'b11
    } zone_e;

    typedef enum logic [1:0] {
        OWN_SEALED = 2'b00,
        OWN_Z1     = 2'b01,
        OWN_Z2     = 2'b10,
        OWN_OPEN   = 2'b11
    } owner_e;

    typedef struct packed {
        master_e    master;
        op_e        op;
        zone_e      fetch_zone;
        logic [1:0] locked;
        zone_e      cop;
    } ctx_t;

    function automatic logic is_partial(input logic [1:0] c);
        return (c == 2'b01) || (c == 2'b10);
    endfunction

    function automatic owner_e decode_owner(input logic [1:0] c1, input logic [1:0] c2);
        owner_e o;
        o = OWN_SEALED;
        if (c1 == 2'b11 && c2 == 2'b11)             o = OWN_OPEN;
        else if (is_partial(c1) && c2 == 2'b11)     o = OWN_Z1;
        else if (c1 == 2'b11 && is_partial(c2))     o = OWN_Z2;
        return o;
    endfunction

    function automatic logic owner_locked(input owner_e o, input logic [1:0] lk);
        return (o == OWN_Z1) ? lk[0] : (o == OWN_Z2) ? lk[1] : 1'b0;
    endfunction

    function automatic logic zone_is(input owner_e o, input zone_e z);
        return (o == OWN_Z1 && z == ZN_1) || (o == OWN_Z2 && z == ZN_2);
    endfunction

endpackage

// File: rtl/zaf_owner_table.sv
module zaf_owner_table
    import zaf_pkg::*;
#(
    parameter int NB    = 6,
    parameter int NSLOT = 8
) (
    input  logic [2*NB-1:0]          claim_z1,
    input  logic [2*NB-1:0]          claim_z2,
    input  logic [NB-1:0]            xonly_mask,
    output owner_e [NSLOT-1:0]       owners,
    output logic [NSLOT-1:0]         xonly
);
    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        if (i < NB) begin : g_real
            assign owners[i] = decode_owner(claim_z1[2*i +: 2], claim_z2[2*i +: 2]);
            assign xonly[i]  = xonly_mask[i];
        end else begin : g_pad
            assign owners[i] = OWN_SEALED;
            assign xonly[i]  = 1'b0;
        end
    end
endmodule

// File: rtl/zaf_policy.sv
module zaf_policy
    import zaf_pkg::*;
(
    input  ctx_t   ctx,
    input  owner_e owner,
    input  logic   xonly,
    output logic   allow
);
    logic locked;
    logic data_op;

    assign locked  = owner_locked(owner, ctx.locked);
    assign data_op = (ctx.op == OP_READ) || (ctx.op == OP_WRITE);

    always_comb begin
        allow = 1'b0;
        if (owner != OWN_SEALED && ctx.op != OP_RSV) begin
            unique case (ctx.master)
                MST_CPU: begin
                    if (ctx.op == OP_FETCH)        allow = 1'b1;
                    else if (owner == OWN_OPEN)    allow = 1'b1;
                    else if (!locked)              allow = 1'b1;
                    else                           allow = zone_is(owner, ctx.fetch_zone)
                                                           && !(ctx.op == OP_READ && xonly);
                end
                MST_DBG: begin
                    allow = (owner == OWN_OPEN) || !locked;
                end
                MST_COP: begin
                    if (ctx.cop == ZN_1 || ctx.cop == ZN_2) begin
                        if (owner == OWN_OPEN) allow = data_op;
                        else                   allow = zone_is(owner, ctx.cop);
                    end else begin
                        allow = (owner == OWN_OPEN);
                    end
                end
                default: allow = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/zaf_rsp_gate.sv
module zaf_rsp_gate #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_fire,
    input  logic              rd_ok,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    logic ok_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            ok_q      <= 1'b0;
        end else begin
            rsp_valid <= rd_fire;
            ok_q      <= rd_fire && rd_ok;
        end
    end

    assign rsp_rdata = ok_q ? mem_rdata : '0;
endmodule

// File: rtl/zone_access_filter.sv
module zone_access_filter
    import zaf_pkg::*;
#(
    parameter int  NB     = 6,
    parameter int  DATA_W = 32,
    localparam int BLK_W  = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_master,
    input  logic [1:0]        req_op,
    input  logic [BLK_W-1:0]  req_blk,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        fetch_zone,
    input  logic [1:0]        zone_locked,
    input  logic [2*NB-1:0]   claim_z1,
    input  logic [2*NB-1:0]   claim_z2,
    input  logic [1:0]        cop_zone,
    input  logic [NB-1:0]     xonly_mask,
    output logic              acc_grant,
    output logic              mem_en,
    output logic              mem_we,
    output logic [BLK_W-1:0]  mem_blk,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    localparam int NSLOT = 1 << BLK_W;

    owner_e [NSLOT-1:0] owners;
    logic   [NSLOT-1:0] xonly;
    ctx_t               ctx;
    logic               allow;
    logic               rd_fire;

    zaf_owner_table #(.NB(NB), .NSLOT(NSLOT)) u_table (
        .claim_z1   (claim_z1),
        .claim_z2   (claim_z2),
        .xonly_mask (xonly_mask),
        .owners     (owners),
        .xonly      (xonly)
    );

    assign ctx.master     = master_e'(req_master);
    assign ctx.op         = op_e'(req_op);
    assign ctx.fetch_zone = zone_e'(fetch_zone);
    assign ctx.locked     = zone_locked;
    assign ctx.cop        = zone_e'(cop_zone);

    zaf_policy u_policy (
        .ctx   (ctx),
        .owner (owners[req_blk]),
        .xonly (xonly[req_blk]),
        .allow (allow)
    );

    assign acc_grant = req_valid && allow;
    assign mem_en    = acc_grant;
    assign mem_we    = acc_grant && (ctx.op == OP_WRITE);
    assign mem_blk   = req_blk;
    assign mem_wdata = mem_we ? req_wdata : '0;
    assign rd_fire   = req_valid && (ctx.op == OP_FETCH || ctx.op == OP_READ);

    zaf_rsp_gate #(.DATA_W(DATA_W)) u_rsp (
        .clk       (clk),
        .rst       (rst),
        .rd_fire   (rd_fire),
        .rd_ok     (allow),
        .mem_rdata (mem_rdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );
endmodule

// File: rtl/zaf_checker.sv
module zaf_checker #(
    parameter int NB     = 6,
    parameter int BLK_W  = 3,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [1:0]        req_master,
    input logic [1:0]        req_op,
    input logic [BLK_W-1:0]  req_blk,
    input logic [1:0]        zone_locked,
    input logic [2*NB-1:0]   claim_z1,
    input logic [2*NB-1:0]   claim_z2,
    input logic              acc_grant,
    input logic              mem_en,
    input logic              mem_we,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata
);
    localparam logic [BLK_W:0] NB_L = NB[BLK_W:0];

    logic       in_rng;
    logic [1:0] c1;
    logic [1:0] c2;
    logic       open_blk;
    logic       sealed;
    logic       rd_req;

    assign in_rng   = {1'b0, req_blk} < NB_L;
    assign c1       = in_rng ? claim_z1[{req_blk, 1'b0} +: 2] : 2'b00;
    assign c2       = in_rng ? claim_z2[{req_blk, 1'b0} +: 2] : 2'b00;
    assign open_blk = (c1 == 2'b11) && (c2 == 2'b11);
    assign sealed   = (c1 == 2'b00) || (c2 == 2'b00) || (c1 != 2'b11 && c2 != 2'b11);
    assign rd_req   = req_valid && (req_op == 2'b00 || req_op == 2'b01);

    AST_SEALED_REFUSED: assert property (@(posedge clk) disable iff (rst)
        req_valid && sealed |-> !acc_grant); // R2

    AST_CPU_FETCH_OPEN: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_master == 2'b00 && req_op == 2'b00 && open_blk |-> acc_grant); // R3

    AST_DBG_LOCKED_OUT: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_master == 2'b01 && zone_locked == 2'b11 && !open_blk |-> !acc_grant); // R6

    AST_REFUSED_NO_RAM: assert property (@(posedge clk) disable iff (rst)
        !acc_grant |-> !mem_en && !mem_we); // R10

    AST_REFUSED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_req && !acc_grant |=> rsp_valid && rsp_rdata == '0); // R9

    AST_NO_RSP_WITHOUT_READ: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !rsp_valid && rsp_rdata == '0); // R9
endmodule

bind zone_access_filter zaf_checker #(.NB(NB), .BLK_W(BLK_W), .DATA_W(DATA_W)) u_zaf_checker (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_master  (req_master),
    .req_op      (req_op),
    .req_blk     (req_blk),
    .zone_locked (zone_locked),
    .claim_z1    (claim_z1),
    .claim_z2    (claim_z2),
    .acc_grant   (acc_grant),
    .mem_en      (mem_en),
    .mem_we      (mem_we),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata)
);

// File: tb/test_zone_access_filter.sv
module test_zone_access_filter;
    localparam int NB     = 6;
    localparam int DATA_W = 32;
    localparam int BLK_W  = 3;
    localparam int NVEC   = 28;

    typedef struct packed {
        logic [1:0] m;
        logic [1:0] op;
        logic [2:0] blk;
        logic [1:0] fz;
        logic [1:0] lk;
        logic [1:0] c1;
        logic [1:0] c2;
        logic [1:0] cop;
        logic       xo;
        logic       exp;
        logic [3:0] rq;
    } vec_t;

    // fields: master, op, block, fetch_zone, locked, claim1, claim2, cop_zone, xonly, expected grant, req
    localparam vec_t VECS [NVEC] = '{
        '{2'b00, 2'b01, 3'd1, 2'b00, 2'b11, 2'b11, 2'b11, 2'b00, 1'b0, 1'b1, 4'd4},  // R4 open read
        '{2'b00, 2'b01, 3'd1, 2'b00, 2'b11, 2'b01, 2'b11, 2'b00, 1'b0, 1'b0, 4'd4},  // R4 Z1 read, no zone
        '{2'b00, 2'b01, 3'd1, 2'b01, 2'b11, 2'b01, 2'b11, 2'b00, 1'b0, 1'b1, 4'd4},  // R4 Z1 read from Z1
        '{2'b00, 2'b01, 3'd1, 2'b10, 2'b11, 2'b01, 2'b11, 2'b00, 1'b0, 1'b0, 4'd4},  // R4 Z1 read from Z2
        '{2'b00, 2'b10, 3'd2, 2'b10, 2'b11, 2'b11, 2'b10, 2'b00, 1'b0, 1'b1, 4'd4},  // R4 Z2 write from Z2
        '{2'b00, 2'b10, 3'd2, 2'b01, 2'b11, 2'b11, 2'b10, 2'b00, 1'b0, 1'b0, 4'd4},  // R4 Z2 write from Z1
        '{2'b00, 2'b00, 3'd3, 2'b00, 2'b11, 2'b01, 2'b11, 2'b00, 1'b0, 1'b1, 4'd3},  // R3 fetch Z1 block
        '{2'b00, 2'b00, 3'd3, 2'b01, 2'b11, 2'b11, 2'b01, 2'b00, 1'b0, 1'b1, 4'd3},  // R3 fetch Z2 block from Z1
        '{2'b00, 2'b01, 3'd0, 2'b01, 2'b11, 2'b00, 2'b11, 2'b00, 1'b0, 1'b0, 4'd2},  // R2 claim1 = 00
        '{2'b00, 2'b00, 3'd0, 2'b01, 2'b11, 2'b11, 2'b00, 2'b00, 1'b0, 1'b0, 4'd2},  // R2 claim2 = 00, fetch
        '{2'b00, 2'b01, 3'd4, 2'b01, 2'b11, 2'b01, 2'b10, 2'b00, 1'b0, 1'b0, 4'd1},  // R1 both partial
        '{2'b00, 2'b01, 3'd4, 2'b01, 2'b11, 2'b10, 2'b11, 2'b00, 1'b0, 1'b1, 4'd1},  // R1 claim 10 gives Z1
        '{2'b00, 2'b01, 3'd5, 2'b01, 2'b11, 2'b01, 2'b11, 2'b00, 1'b1, 1'b0, 4'd5},  // R5 xonly read refused
        '{2'b00, 2'b00, 3'd5, 2'b01, 2'b11, 2'b01, 2'b11, 2'b00, 1'b1, 1'b1, 4'd5},  // R5 xonly fetch
        '{2'b00, 2'b10, 3'd5, 2'b01, 2'b11, 2'b01, 2'b11, 2'b00, 1'b1, 1'b1, 4'd5},  // R5 xonly write
        '{2'b01, 2'b01, 3'd1, 2'b01, 2'b11, 2'b01, 2'b11, 2'b00, 1'b0, 1'b0, 4'd6},  // R6 debug read Z1 locked
        '{2'b01, 2'b10, 3'd1, 2'b00, 2'b11, 2'b11, 2'b11, 2'b00, 1'b0, 1'b1, 4'd6},  // R6 debug write open
        '{2'b01, 2'b01, 3'd1, 2'b00, 2'b10, 2'b01, 2'b11, 2'b00, 1'b0, 1'b1, 4'd7},  // R7 debug read Z1 unlocked
        '{2'b00, 2'b01, 3'd1, 2'b10, 2'b10, 2'b01, 2'b11, 2'b00, 1'b1, 1'b1, 4'd7},  // R7 cpu read Z1 unlocked xonly
        '{2'b01, 2'b01, 3'd2, 2'b00, 2'b10, 2'b11, 2'b01, 2'b00, 1'b0, 1'b0, 4'd6},  // R6 debug read Z2 locked
        '{2'b10, 2'b00, 3'd1, 2'b00, 2'b11, 2'b11, 2'b11, 2'b00, 1'b0, 1'b1, 4'd8},  // R8 cop none fetch open
        '{2'b10, 2'b01, 3'd1, 2'b00, 2'b11, 2'b01, 2'b11, 2'b00, 1'b0, 1'b0, 4'd8},  // R8 cop none read Z1
        '{2'b10, 2'b00, 3'd1, 2'b00, 2'b11, 2'b01, 2'b11, 2'b01, 1'b0, 1'b1, 4'd8},  // R8 cop Z1 fetch Z1
        '{2'b10, 2'b10, 3'd1, 2'b00, 2'b11, 2'b11, 2'b01, 2'b01, 1'b0, 1'b0, 4'd8},  // R8 cop Z1 write Z2
        '{2'b10, 2'b00, 3'd1, 2'b00, 2'b11, 2'b11, 2'b11, 2'b10, 1'b0, 1'b0, 4'd8},  // R8 cop Z2 fetch open
        '{2'b10, 2'b01, 3'd1, 2'b00, 2'b11, 2'b11, 2'b11, 2'b10, 1'b0, 1'b1, 4'd8},  // R8 cop Z2 read open
        '{2'b10, 2'b10, 3'd1, 2'b00, 2'b11, 2'b11, 2'b10, 2'b10, 1'b0, 1'b1, 4'd8},  // R8 cop Z2 write Z2
        '{2'b10, 2'b01, 3'd3, 2'b00, 2'b11, 2'b00, 2'b11, 2'b01, 1'b0, 1'b0, 4'd2}   // R2 cop on sealed
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [1:0]        req_master = '0;
    logic [1:0]        req_op = '0;
    logic [BLK_W-1:0]  req_blk = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic [1:0]        fetch_zone = '0;
    logic [1:0]        zone_locked = 2'b11;
    logic [2*NB-1:0]   claim_z1 = '1;
    logic [2*NB-1:0]   claim_z2 = '1;
    logic [1:0]        cop_zone = '0;
    logic [NB-1:0]     xonly_mask = '0;
    logic              acc_grant;
    logic              mem_en;
    logic              mem_we;
    logic [BLK_W-1:0]  mem_blk;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_rdata;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    always_ff @(posedge clk)
        if (mem_en && !mem_we) mem_rdata <= 32'hC0DE_0000 | {29'b0, mem_blk};

    zone_access_filter #(.NB(NB), .DATA_W(DATA_W)) i_zone_access_filter (
        .clk, .rst, .req_valid, .req_master, .req_op, .req_blk, .req_wdata,
        .fetch_zone, .zone_locked, .claim_z1, .claim_z2, .cop_zone, .xonly_mask,
        .acc_grant, .mem_en, .mem_we, .mem_blk, .mem_wdata, .mem_rdata,
        .rsp_valid, .rsp_rdata
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        req_valid  = 1'b1;
        req_master = v.m;
        req_op     = v.op;
        req_blk    = v.blk;
        fetch_zone = v.fz;
        zone_locked = v.lk;
        cop_zone   = v.cop;
        claim_z1   = '1;
        claim_z2   = '1;
        xonly_mask = '0;
        if (v.blk < NB) begin
            claim_z1[2*v.blk +: 2] = v.c1;
            claim_z2[2*v.blk +: 2] = v.c2;
            xonly_mask[v.blk]      = v.xo;
        end
        req_wdata = 32'h5A5A_0000 | {29'b0, v.blk};
    endtask

    task automatic expect_vec(input vec_t v, input string tag);
        logic [31:0] exp_d;
        #1;
        check(acc_grant == v.exp, {tag, " grant"}, {31'b0, acc_grant}, {31'b0, v.exp});
        check(mem_we == (v.exp && v.op == 2'b10), {tag, " R10 write enable"},
              {31'b0, mem_we}, {31'b0, v.exp && v.op == 2'b10});
        @(posedge clk);
        #1;
        exp_d = v.exp ? (32'hC0DE_0000 | {29'b0, v.blk}) : 32'h0;
        if (v.op == 2'b10) begin
            check(!rsp_valid, {tag, " R10 no response on write"}, {31'b0, rsp_valid}, 32'h0);
        end else begin
            check(rsp_valid, {tag, " R9 response valid"}, {31'b0, rsp_valid}, 32'h1);
            check(rsp_rdata == exp_d, {tag, " R9 response data"}, rsp_rdata, exp_d);
        end
    endtask

    initial begin
        #(4 * 20000);
        errors++;
        $display("FAIL watchdog expired: run hung, actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(!rsp_valid, "R11 rsp_valid in reset", {31'b0, rsp_valid}, 32'h0);
        check(rsp_rdata == '0, "R11 rsp_rdata in reset", rsp_rdata, 32'h0);
        check(!acc_grant && !mem_en, "R11 idle grant", {30'b0, acc_grant, mem_en}, 32'h0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i]);
            expect_vec(VECS[i], $sformatf("vec%0d R%0d", i, VECS[i].rq));
        end

        // R2: index past the last block is sealed, all claim fields open
        begin
            vec_t v;
            v = '{2'b00, 2'b00, 3'd6, 2'b00, 2'b00, 2'b11, 2'b11, 2'b00, 1'b0, 1'b0, 4'd2};
            apply(v);
            expect_vec(v, "R2 index out of range");
            v = '{2'b01, 2'b01, 3'd7, 2'b00, 2'b00, 2'b11, 2'b11, 2'b00, 1'b0, 1'b0, 4'd2};
            apply(v);
            expect_vec(v, "R2 debug index out of range");
        end

        // R9: back-to-back granted then refused then granted reads
        begin
            vec_t a, b;
            a = '{2'b00, 2'b01, 3'd2, 2'b00, 2'b11, 2'b11, 2'b11, 2'b00, 1'b0, 1'b1, 4'd9};
            b = '{2'b00, 2'b01, 3'd3, 2'b10, 2'b11, 2'b01, 2'b11, 2'b00, 1'b0, 1'b0, 4'd9};
            apply(a);
            expect_vec(a, "R9 b2b first");
            apply(b);
            expect_vec(b, "R9 b2b refused");
            apply(a);
            expect_vec(a, "R9 b2b third");
        end

        // R10: refused write leaves RAM untouched
        @(negedge clk);
        req_valid = 1'b1; req_master = 2'b01; req_op = 2'b10; req_blk = 3'd0;
        zone_locked = 2'b11; claim_z1 = '1; claim_z2 = '1; claim_z1[1:0] = 2'b01;
        #1;
        check(!mem_en && !mem_we, "R10 debug write to locked block", {30'b0, mem_en, mem_we}, 32'h0);
        check(mem_wdata == '0, "R10 write data held back", mem_wdata, 32'h0);

        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk);
        #1;
        check(!rsp_valid, "R9 idle no response", {31'b0, rsp_valid}, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule